// File: doc/BRIEF.md
# Bridge Configuration Cycle Translator

This block sits inside a virtual bridge between a host's primary bus (bus 0) and a secondary graphics port. It inspects each configuration request arriving on the primary side. It then either forwards the request to the secondary port or reports that the request was not claimed.

A Type 1 request addressed to the secondary bus itself becomes a Type 0 request with a one-hot device select line. A Type 1 request addressed to a bus further downstream, up to the subordinate bus, is passed on unchanged as Type 1. The block also holds three bus number registers: primary, secondary and subordinate. The primary register is fixed at zero.

Each decision is registered one clock after the request strobe. A forwarded request stays on the outputs until the consumer acknowledges it. The downstream consumer acknowledges with a single-cycle `out_ack`.

Top module: `cfg_fwd_xlate`

## Requirements
- R1: Reading register select 0 (primary bus number) always returns 0; writes to select 0 have no effect.
- R2: The secondary (select 1) and subordinate (select 2) registers are 8-bit, writable, read back their value, and reset to 0; select 3 reads 0.
- R3: A request with `req_type1`=0 is never forwarded and never flagged as unclaimed.
- R4: A Type 1 request whose bus equals a non-zero secondary number is forwarded with `out_type1`=0, `out_addr` = {zeros, fn[2:0], reg[5:0], 2'b00}, and `out_idsel` having only bit `req_dev` set.
- R5: A Type 1 request with bus non-zero, greater than secondary, and at most subordinate is forwarded with `out_type1`=1, `out_addr` = {8'b0, bus[7:0], dev[4:0], fn[2:0], reg[5:0], 2'b01}, and `out_idsel`=0.
- R6: Any other Type 1 request, including every Type 1 request while both registers are 0, produces no output and asserts `unclaimed` for exactly one cycle.
- R7: Byte enables and the write flag of a forwarded request appear unchanged on `out_be` and `out_wr`.
- R8: A decision is visible in the cycle after the clock edge that samples `req_valid`. Forwarded outputs then hold steady until `out_ack`, and `out_valid` is low from the edge that samples `out_ack`.
- R9: A request presented while `out_valid` is high is ignored: no flag, no change to the held output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_type1 | input | 1 | 1 = Type 1 request, 0 = Type 0 |
| req_bus | input | 8 | Target bus number |
| req_dev | input | 5 | Target device number |
| req_fn | input | 3 | Target function number |
| req_reg | input | 6 | Dword register number |
| req_be | input | 4 | Byte enables |
| req_wr | input | 1 | 1 = write, 0 = read |
| out_ack | input | 1 | Consumer accepts forwarded request |
| reg_wr_en | input | 1 | Bus number register write strobe |
| reg_sel | input | 2 | Register select: 0 primary, 1 secondary, 2 subordinate |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for `reg_sel` |
| out_valid | output | 1 | Forwarded request pending |
| out_type1 | output | 1 | Forwarded type: 1 = Type 1, 0 = Type 0 |
| out_addr | output | 32 | Forwarded address |
| out_idsel | output | 32 | One-hot device select for Type 0 |
| out_be | output | 4 | Forwarded byte enables |
| out_wr | output | 1 | Forwarded write flag |
| unclaimed | output | 1 | One-cycle pulse for a Type 1 request not claimed |

## Verification
The hardest situations to reach are the range edges. These are a bus exactly one above secondary, a bus exactly equal to subordinate, and a bus one past subordinate. They must also be combined with register settings where secondary is zero, equal to subordinate, or above it. Random stimulus rarely lands on these points with uniform bus numbers. So the random bus is drawn near the programmed secondary and subordinate values, and directed cases pin each edge. A second request presented while a forwarded one waits unacknowledged is issued on purpose, to show it leaves no trace.

// File: rtl/cfg_fwd_xlate.sv
module cfg_fwd_xlate #(
  parameter int BUS_W = 8,
  parameter int DEV_W = 5,
  parameter int FN_W  = 3,
  parameter int REG_W = 6,
  parameter int BE_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_type1,
  input  logic [BUS_W-1:0]   req_bus,
  input  logic [DEV_W-1:0]   req_dev,
  input  logic [FN_W-1:0]    req_fn,
  input  logic [REG_W-1:0]   req_reg,
  input  logic [BE_W-1:0]    req_be,
  input  logic               req_wr,
  input  logic               out_ack,
  input  logic               reg_wr_en,
  input  logic [1:0]         reg_sel,
  input  logic [BUS_W-1:0]   reg_wdata,
  output logic [BUS_W-1:0]   reg_rdata,
  output logic               out_valid,
  output logic               out_type1,
  output logic [31:0]        out_addr,
  output logic [(1<<DEV_W)-1:0] out_idsel,
  output logic [BE_W-1:0]    out_be,
  output logic               out_wr,
  output logic               unclaimed
);
  localparam int NDEV   = 1 << DEV_W;
  localparam int ADDR_W = 32;
  localparam int T0_W   = FN_W + REG_W + 2;
  localparam int T1_W   = BUS_W + DEV_W + T0_W;

  logic [BUS_W-1:0] sec_q, sub_q;

  wire accept = req_valid && !out_valid;
  wire hit_t0 = req_type1 && (req_bus == sec_q) && (sec_q != '0);
  wire hit_t1 = req_type1 && (req_bus != '0) && (req_bus > sec_q) && (req_bus <= sub_q);
  wire hit    = hit_t0 || hit_t1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q     <= '0;
      sub_q     <= '0;
      out_valid <= 1'b0;
      out_type1 <= 1'b0;
      out_addr  <= '0;
      out_idsel <= '0;
      out_be    <= '0;
      out_wr    <= 1'b0;
      unclaimed <= 1'b0;
    end else begin
      if (reg_wr_en && reg_sel == 2'd1) sec_q <= reg_wdata;
      if (reg_wr_en && reg_sel == 2'd2) sub_q <= reg_wdata;
      unclaimed <= accept && req_type1 && !hit;
      if (out_valid && out_ack)
        out_valid <= 1'b0;
      else if (accept && hit) begin
        out_valid <= 1'b1;
        out_type1 <= hit_t1;
        out_be    <= req_be;
        out_wr    <= req_wr;
        if (hit_t1) begin
          out_addr  <= ADDR_W'({req_bus, req_dev, req_fn, req_reg, 2'b01});
          out_idsel <= '0;
        end else begin
          out_addr  <= ADDR_W'({req_fn, req_reg, 2'b00});
          out_idsel <= NDEV'(1) << req_dev;
        end
      end
    end
  end

  always_comb begin
    case (reg_sel)
      2'd1:    reg_rdata = sec_q;
      2'd2:    reg_rdata = sub_q;
      default: reg_rdata = '0;
    endcase
  end

  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ack |=> out_valid && $stable(out_addr) && $stable(out_type1) && $stable(out_be)); // R8
  AST_DROP_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ack |=> !out_valid); // R8
  AST_RISE_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(req_valid)); // R8
  AST_T0_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_type1 |-> $countones(out_idsel) == 1 && out_addr[1:0] == 2'b00); // R4
  AST_T1_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_type1 |-> out_idsel == '0 && out_addr[1:0] == 2'b01 && out_addr[T1_W-1 -: BUS_W] != '0); // R5
  AST_UNCL_NO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    unclaimed |-> !out_valid); // R6
  AST_BUSY_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ack |=> !unclaimed); // R9
  AST_PRI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel == 2'd0 |-> reg_rdata == '0); // R1
endmodule

// File: tb/tb_cfg_fwd_xlate.sv
module tb_cfg_fwd_xlate;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_type1 = 0, req_wr = 0, out_ack = 0, reg_wr_en = 0;
  logic [7:0] req_bus = 0, reg_wdata = 0;
  logic [4:0] req_dev = 0;
  logic [2:0] req_fn = 0;
  logic [5:0] req_reg = 0;
  logic [3:0] req_be = 0;
  logic [1:0] reg_sel = 0;
  logic [7:0] reg_rdata;
  logic out_valid, out_type1, out_wr, unclaimed;
  logic [31:0] out_addr, out_idsel;
  logic [3:0] out_be;
  int tests = 0, fails = 0;
  bit done = 0;
  logic [7:0] m_sec = 0, m_sub = 0;

  always #4 clk = ~clk;

  cfg_fwd_xlate dut (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // 0 none, 1 type0, 2 type1, 3 unclaimed
  function automatic int predict(input logic t1, input logic [7:0] bus);
    if (!t1) return 0;
    if (bus == m_sec && m_sec != 0) return 1;
    if (bus != 0 && bus > m_sec && bus <= m_sub) return 2;
    return 3;
  endfunction

  task automatic wreg(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk); reg_wr_en = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_wr_en = 0;
    if (sel == 1) m_sec = d;
    if (sel == 2) m_sub = d;
  endtask

  task automatic send(input logic t1, input logic [7:0] bus, input logic [4:0] dev,
                      input logic [2:0] fn, input logic [5:0] rg, input logic [3:0] be,
                      input logic wr, input bit hold);
    int k;
    logic [31:0] ea, ei;
    k = predict(t1, bus);
    @(negedge clk);
    req_valid = 1; req_type1 = t1; req_bus = bus; req_dev = dev; req_fn = fn;
    req_reg = rg; req_be = be; req_wr = wr;
    @(negedge clk);
    req_valid = 0;
    chk("R6 unclaimed", unclaimed, k == 3);
    chk(k == 0 ? "R3 type0 in" : "R8 valid", out_valid, k == 1 || k == 2);
    if (k == 1 || k == 2) begin
      ea = (k == 2) ? {8'h0, bus, dev, fn, rg, 2'b01} : {21'h0, fn, rg, 2'b00};
      ei = (k == 1) ? (32'h1 << dev) : 32'h0;
      chk(k == 2 ? "R5 type" : "R4 type", out_type1, k == 2);
      chk(k == 2 ? "R5 addr" : "R4 addr", out_addr, ea);
      chk(k == 2 ? "R5 idsel" : "R4 idsel", out_idsel, ei);
      chk("R7 be", out_be, be);
      chk("R7 wr", out_wr, wr);
      if (hold) begin
        req_valid = 1; req_type1 = 1; req_bus = 8'hFF; req_dev = ~dev;
        @(negedge clk); req_valid = 0;
        chk("R9 busy unclaimed", unclaimed, 0);
        chk("R9 busy addr", out_addr, ea);
        @(negedge clk);
        chk("R8 hold valid", out_valid, 1);
        chk("R8 hold addr", out_addr, ea);
      end
      out_ack = 1;
      @(negedge clk); out_ack = 0;
      chk("R8 drop", out_valid, 0);
    end else begin
      @(negedge clk);
      chk("R6 one cycle", unclaimed, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R8 reset valid", out_valid, 0);
    chk("R6 reset flag", unclaimed, 0);
    reg_sel = 1; #1 chk("R2 reset sec", reg_rdata, 0);
    reg_sel = 2; #1 chk("R2 reset sub", reg_rdata, 0);
    send(1, 0, 3, 1, 2, 4'hF, 0, 0);
    send(1, 5, 3, 1, 2, 4'hF, 0, 0);
    wreg(0, 8'h5A);
    reg_sel = 0; #1 chk("R1 primary", reg_rdata, 0);
    wreg(1, 8'd4); wreg(2, 8'd9);
    reg_sel = 1; #1 chk("R2 sec", reg_rdata, 4);
    reg_sel = 2; #1 chk("R2 sub", reg_rdata, 9);
    reg_sel = 3; #1 chk("R2 sel3", reg_rdata, 0);
    send(0, 4, 7, 2, 9, 4'h3, 1, 0);
    send(1, 4, 31, 7, 63, 4'h1, 1, 1);
    send(1, 4, 0, 0, 0, 4'h8, 0, 0);
    send(1, 5, 17, 3, 21, 4'hC, 1, 1);
    send(1, 9, 2, 5, 33, 4'h6, 0, 0);
    send(1, 10, 2, 5, 33, 4'h6, 0, 0);
    send(1, 3, 2, 5, 33, 4'h6, 0, 0);
    wreg(1, 8'd7); wreg(2, 8'd7);
    send(1, 7, 1, 1, 1, 4'hF, 1, 0);
    send(1, 8, 1, 1, 1, 4'hF, 1, 0);
    wreg(1, 8'd20); wreg(2, 8'd10);
    send(1, 15, 1, 1, 1, 4'hF, 1, 0);
    void'($urandom(32'd1234));
    for (int i = 0; i < 300; i++) begin
      logic [7:0] b;
      if (i % 20 == 0) begin
        wreg(1, 8'($urandom_range(0, 40)));
        wreg(2, 8'(m_sec + $urandom_range(0, 30)));
      end
      case ($urandom_range(0, 3))
        0: b = m_sec;
        1: b = m_sub + 8'($urandom_range(0, 2)) - 8'd1;
        2: b = m_sec + 8'($urandom_range(0, 2));
        default: b = 8'($urandom);
      endcase
      send(($urandom_range(0, 7) != 0), b, 5'($urandom), 3'($urandom), 6'($urandom),
           4'($urandom), 1'($urandom), ($urandom_range(0, 3) == 0));
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog R8 actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule